// File: doc/BRIEF.md
# Long-Word Read Unpacker

This block sits between the output of a queue that stores 36-bit long words and a read port that may be narrower. The read port is set to one of three widths. In full width, each read returns one whole long word. In word width, each long word comes out as two 18-bit reads. In byte width, it comes out as four 9-bit reads. For the narrow widths an endian setting picks the order of the pieces: either the most significant piece first, or the least significant piece first.

A long word is taken from the queue by a valid/ready pull. The first piece goes to the read data register. The whole word is kept in a holding register, and later reads take the remaining pieces from there. The next long word is pulled only on a read that finds no pieces left in the holding register. The width and endian inputs are captured while reset is held, so the value present when reset is released stays in force until the next reset.

Top module: `lw_unpacker`

## Requirements
- R1: With width code 2'b00 (or the spare code 2'b11), every accepted read loads the whole 36-bit queue word into `rdData` and pulls exactly one word from the queue.
- R2: With width code 2'b01 and `cfgBigIn`=1, the two reads of a long word return bits 35:18 and then bits 17:0, placed on `rdData[17:0]`, with `rdData[35:18]` zero.
- R3: With width code 2'b01 and `cfgBigIn`=0, the two reads return bits 17:0 and then bits 35:18 on `rdData[17:0]`, with `rdData[35:18]` zero.
- R4: With width code 2'b10 and `cfgBigIn`=1, the four reads return bits 35:27, 26:18, 17:9 and 8:0 on `rdData[8:0]`, with `rdData[35:9]` zero.
- R5: With width code 2'b10 and `cfgBigIn`=0, the four reads return bits 8:0, 17:9, 26:18 and 35:27 on `rdData[8:0]`, with `rdData[35:9]` zero.
- R6: In full width the endian input has no effect on the data returned.
- R7: Width and endian are the values on `cfgSizeIn` and `cfgBigIn` in the last clock cycle with `rstN` low. Later changes to those inputs have no effect until the next reset.
- R8: `inReady` is high only during a read that finds no pieces held, so that cycle pops one word. All held pieces are returned before the next word is pulled.
- R9: `rdEmpty` is high exactly when no pieces are held and `inValid` is low. A read while `rdEmpty` is high changes neither `rdData` nor the queue.
- R10: `rdData` changes only on the clock edge that takes a read (`rdEn` high and `rdEmpty` low). Otherwise it holds its value, and it is zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; width and endian are captured while it is low |
| cfgSizeIn | input | 2 | Read width: 00 full, 01 word, 10 byte, 11 full |
| cfgBigIn | input | 1 | 1 = most significant piece first, 0 = least significant first |
| inData | input | 36 | Long word at the head of the queue |
| inValid | input | 1 | Queue head holds a word |
| inReady | output | 1 | Pops the queue head in this cycle |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Piece returned by the most recent accepted read |
| rdEmpty | output | 1 | Nothing available to read |

## Verification
A wrong piece count or index in the control shows up at the ports on the very next read. Either a piece from the wrong lane appears, or the queue is popped one read too early or too late. This is caught by following `inReady` read by read across whole long words in each width and order. A width or endian setting that is lost after reset shows up on the first narrow read, so the bench changes both inputs right after reset is released in every scenario. A fault in the holding register shows up only on the second and later pieces of a word, so every scenario reads full long words to the end and checks each piece.

// File: rtl/unp_pkg.sv
package unp_pkg;
  localparam int LANES = 4;
  localparam int IDX_W = $clog2(LANES);
  localparam int CNT_W = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_SPARE = 2'b11
  } busSizeE;

  typedef struct packed {
    logic             loadNew;   // take a fresh long word from the queue
    logic             emitHeld;  // return a held piece
    logic [IDX_W-1:0] pieceIdx;  // sequence position of the returned piece
  } stepT;
endpackage

// File: rtl/unp_ctrl.sv
module unp_ctrl
  import unp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgSizeIn,
  input  logic       cfgBigIn,
  input  logic       inValid,
  input  logic       rdEn,
  output busSizeE    cfgSize,
  output logic       cfgBig,
  output logic       inReady,
  output logic       rdEmpty,
  output stepT       step
);
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] piecesM1;
  logic [IDX_W-1:0] pos;
  logic             rdFire;

  always_comb begin
    case (cfgSize)
      SZ_WORD: piecesM1 = CNT_W'(1);
      SZ_BYTE: piecesM1 = CNT_W'(LANES - 1);
      default: piecesM1 = '0;
    endcase
  end

  assign rdEmpty       = (remain == '0) && !inValid;
  assign rdFire        = rdEn && !rdEmpty;
  assign step.loadNew  = rdFire && (remain == '0);
  assign step.emitHeld = rdFire && (remain != '0);
  assign step.pieceIdx = step.loadNew ? '0 : pos;
  assign inReady       = step.loadNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSize <= busSizeE'(cfgSizeIn);
      cfgBig  <= cfgBigIn;
      remain  <= '0;
      pos     <= '0;
    end else if (step.loadNew) begin
      remain <= piecesM1;
      pos    <= IDX_W'(1);
    end else if (step.emitHeld) begin
      remain <= remain - CNT_W'(1);
      pos    <= pos + IDX_W'(1);
    end
  end

  // R8
  pop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> inValid);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ($stable(cfgSize) && $stable(cfgBig)));

  // R8
  held_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    remain <= piecesM1);

  // R9
  empty_no_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEmpty |-> !inReady);
endmodule

// File: rtl/unp_data.sv
module unp_data
  import unp_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busSizeE                   cfgSize,
  input  logic                      cfgBig,
  input  stepT                      step,
  input  logic [LANE_W*LANES-1:0]   inData,
  output logic [LANE_W*LANES-1:0]   rdData
);
  localparam int LONG_W = LANE_W * LANES;
  localparam int HALF_W = LONG_W / 2;

  logic [LONG_W-1:0] holdReg;
  logic [LONG_W-1:0] srcWord;
  logic [LONG_W-1:0] piece;
  logic [LANE_W-1:0] lane [LANES];
  logic [HALF_W-1:0] half [2];
  logic [IDX_W-1:0]  laneSel;
  logic              halfSel;

  assign srcWord = step.loadNew ? inData : holdReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = srcWord[g*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half[h] = srcWord[h*HALF_W +: HALF_W];
  end

  assign laneSel = cfgBig ? (IDX_W'(LANES - 1) - step.pieceIdx) : step.pieceIdx;
  assign halfSel = cfgBig ? ~step.pieceIdx[0] : step.pieceIdx[0];

  always_comb begin
    case (cfgSize)
      SZ_WORD: piece = LONG_W'(half[halfSel]);
      SZ_BYTE: piece = LONG_W'(lane[laneSel]);
      default: piece = srcWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
      rdData  <= '0;
    end else begin
      if (step.loadNew) holdReg <= inData;
      if (step.loadNew || step.emitHeld) rdData <= piece;
    end
  end

  // R4 R5
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSize == SZ_BYTE) |-> (rdData[LONG_W-1:LANE_W] == '0));

  // R2 R3
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSize == SZ_WORD) |-> (rdData[LONG_W-1:HALF_W] == '0));

  // R1
  long_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step.loadNew && (cfgSize == SZ_LONG)) |=> (rdData == $past(inData)));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !step.loadNew && !step.emitHeld) |=> $stable(rdData));
endmodule

// File: rtl/lw_unpacker.sv
module lw_unpacker
  import unp_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              cfgSizeIn,
  input  logic                    cfgBigIn,
  input  logic [LANE_W*LANES-1:0] inData,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic                    rdEn,
  output logic [LANE_W*LANES-1:0] rdData,
  output logic                    rdEmpty
);
  busSizeE cfgSize;
  logic    cfgBig;
  stepT    step;

  unp_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgSizeIn(cfgSizeIn), .cfgBigIn(cfgBigIn),
    .inValid(inValid), .rdEn(rdEn), .cfgSize(cfgSize), .cfgBig(cfgBig),
    .inReady(inReady), .rdEmpty(rdEmpty), .step(step)
  );

  unp_data #(.LANE_W(LANE_W)) i_data (
    .clk(clk), .rstN(rstN), .cfgSize(cfgSize), .cfgBig(cfgBig),
    .step(step), .inData(inData), .rdData(rdData)
  );
endmodule

// File: tb/test_lw_unpacker.sv
`timescale 1ns/1ps
module test_lw_unpacker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgSizeIn = 2'b00;
  logic        cfgBigIn = 1'b0;
  logic [35:0] inData;
  logic        inValid;
  logic        inReady;
  logic        rdEn = 1'b0;
  logic [35:0] rdData;
  logic        rdEmpty;

  int checks = 0;
  int errors = 0;

  logic [35:0] qMem [64];
  logic [5:0]  wrPtr = '0;
  logic [5:0]  rdPtr = '0;

  always #4 clk = ~clk;

  assign inValid = (wrPtr != rdPtr);
  assign inData  = qMem[rdPtr];

  always @(posedge clk) if (inReady) rdPtr <= rdPtr + 6'd1;

  lw_unpacker i_lw_unpacker (
    .clk(clk), .rstN(rstN), .cfgSizeIn(cfgSizeIn), .cfgBigIn(cfgBigIn),
    .inData(inData), .inValid(inValid), .inReady(inReady), .rdEn(rdEn),
    .rdData(rdData), .rdEmpty(rdEmpty)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] expPiece(input logic [1:0] sz, input logic big,
                                           input logic [35:0] w, input int k);
    int sh;
    if (sz == 2'b01) begin
      sh = big ? 18 * (1 - k) : 18 * k;
      return (w >> sh) & 36'h3FFFF;
    end else if (sz == 2'b10) begin
      sh = big ? 9 * (3 - k) : 9 * k;
      return (w >> sh) & 36'h1FF;
    end
    return w;
  endfunction

  function automatic int pieceCount(input logic [1:0] sz);
    return (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
  endfunction

  // reset with a chosen setting, then scramble the setting inputs (R7)
  task automatic doReset(input logic [1:0] sz, input logic big);
    @(negedge clk);
    rstN = 1'b0; cfgSizeIn = sz; cfgBigIn = big; rdEn = 1'b0;
    wrPtr = rdPtr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cfgSizeIn = (sz == 2'b10) ? 2'b01 : 2'b10;
    cfgBigIn = ~big;
  endtask

  task automatic push(input logic [35:0] w);
    qMem[wrPtr] = w;
    wrPtr = wrPtr + 6'd1;
  endtask

  task automatic readOne();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic runWords(input string req, input logic [1:0] sz, input logic big);
    logic [35:0] w [3];
    w[0] = 36'h123456789; w[1] = 36'hFEDCBA987; w[2] = 36'h5A5A0F0F3;
    doReset(sz, big);
    for (int i = 0; i < 3; i++) push(w[i]);
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < pieceCount(sz); k++) begin
        readOne();
        chk(req, rdData, expPiece(sz, big, w[i], k));
      end
    chk({req, " queue drained"}, 36'(wrPtr - rdPtr), 36'd0);
  endtask

  task automatic t_reset();
    doReset(2'b01, 1'b1);
    @(negedge clk);
    chk("R10 rdData zero after reset", rdData, 36'd0);
    chk("R9 empty after reset", 36'(rdEmpty), 36'd1);
    push(36'h0ABCDE123);
    #1 chk("R9 not empty with valid", 36'(rdEmpty), 36'd0);
    repeat (3) @(negedge clk);
    chk("R10 holds without read", rdData, 36'd0);
    chk("R8 no pop without read", 36'(rdPtr), 36'(wrPtr - 6'd1));
    readOne(); readOne();
  endtask

  task automatic t_long();
    runWords("R1 long", 2'b00, 1'b0);
    runWords("R6 long endian ignored", 2'b00, 1'b1);
    runWords("R1 spare code as long", 2'b11, 1'b1);
  endtask

  task automatic t_word();
    runWords("R2 word big", 2'b01, 1'b1);
    runWords("R3 word little", 2'b01, 1'b0);
  endtask

  task automatic t_byte();
    runWords("R4 R7 byte big", 2'b10, 1'b1);
    runWords("R5 R7 byte little", 2'b10, 1'b0);
  endtask

  task automatic t_pop_order();
    logic [5:0] base;
    doReset(2'b10, 1'b0);
    base = rdPtr;
    push(36'h111111111); push(36'h222222222);
    readOne();
    chk("R8 pop on first piece", 36'(rdPtr - base), 36'd1);
    readOne(); readOne(); readOne();
    chk("R8 no pop on held pieces", 36'(rdPtr - base), 36'd1);
    readOne();
    chk("R8 next word after held", 36'(rdPtr - base), 36'd2);
    chk("R8 first piece of next", rdData, expPiece(2'b10, 1'b0, 36'h222222222, 0));
    readOne(); readOne(); readOne();
  endtask

  task automatic t_empty();
    logic [35:0] last;
    logic [5:0]  base;
    doReset(2'b01, 1'b0);
    push(36'h9876543AB);
    readOne();
    #1 chk("R9 not empty while piece held", 36'(rdEmpty), 36'd0);
    readOne();
    last = rdData;
    #1 chk("R9 empty when drained", 36'(rdEmpty), 36'd1);
    base = rdPtr;
    readOne();
    chk("R9 read while empty keeps data", rdData, last);
    chk("R9 read while empty no pop", 36'(rdPtr - base), 36'd0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_long();
        t_word();
        t_byte();
        t_pop_order();
        t_empty();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule